// File: doc/BRIEF.md
# Event Log Ring Writer with Sticky Overflow

This block takes fixed-width event records from internal fault sources over a valid/ready port. It stores each accepted record in a circular log. The log lives in an on-chip memory, and the block drives that memory through a simple write port. The block owns the tail (producer) pointer. Software owns the head (consumer) pointer and advances it through a small register interface once it has drained entries. A status register holds write-1-to-clear bits for "entries pending" and "overflow". A control register holds a log-enable bit and an interrupt-enable bit. One interrupt line combines the status bits with the enable.

The ring depth is a power of two, and one slot always stays empty, so the ring holds at most DEPTH-1 records. When a record arrives and no free slot is left, the record is dropped, a sticky overflow flag is set, and logging stops. Logging stays stopped even after software frees space. To restart, software clears the overflow flag, writes log-enable to 0, and then writes it to 1. Record sources are never stalled while the flag is up: they see ready and their records are discarded.

Register map (`reg_addr`): 0 = control (bit 0 log-enable, bit 1 interrupt-enable), 1 = status (bit 0 pending, bit 1 overflow), 2 = head pointer (read/write, low bits), 3 = tail pointer (read only). Reads are combinational. Writes take effect at the next clock edge.

Top module: `evlog_ring`

## Requirements
- R1: After reset, control, status, head and tail all read 0, `irq` is 0 and `evt_ready` is 0.
- R2: While logging is active and the ring is not full, an accepted record drives `mem_we`=1 in the same cycle, with `mem_addr` equal to the tail and `mem_wdata` equal to the record. The tail then advances by one, wrapping from DEPTH-1 to 0, and status bit 0 (pending) is set.
- R3: The ring is full when (tail+1) mod DEPTH equals head. A record accepted while the ring is full is not written. It sets status bit 1 (overflow) and makes logging inactive.
- R4: While overflow is set, `evt_ready` is 1 and every record is dropped without a memory write, even if head has moved to free slots.
- R5: Writing address 1 clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged. A pending set in the same cycle as its clear leaves the bit at 1.
- R6: Logging becomes active only when control bit 0 is written 1 while it reads 0 and overflow is 0. Writing 1 while it already reads 1 does not restart logging.
- R7: `irq` equals control bit 1 AND (status bit 0 OR status bit 1).
- R8: Writing control bit 0 as 0 makes logging inactive from the next cycle. `evt_ready` is then 0 while overflow is 0, and head and tail keep their values.
- R9: Writing address 2 loads the head pointer, and the next full decision uses the new head. Writes to address 3 leave the tail unchanged.
- R10: `reg_rdata` shows the register selected by `reg_addr` in the same cycle, with unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Record offered |
| evt_data | input | REC_W | Record contents |
| evt_ready | output | 1 | Record taken this cycle (stored or dropped) |
| mem_we | output | 1 | Log memory write strobe |
| mem_addr | output | $clog2(DEPTH) | Log memory slot index |
| mem_wdata | output | REC_W | Log memory write data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | CSR_W | Register write data |
| reg_rdata | output | CSR_W | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
A lost or stale overflow flag appears at the ports in the cycle of the next offered record: `mem_we` rises when it must stay low, or `evt_ready` takes the wrong level, and `irq` disagrees at once. A tail pointer off by one appears on `mem_addr` at the next write. It also appears as an early or late overflow when the ring fills. A bad arm state appears as `evt_ready` out of step with the control write sequence. The bench therefore compares every output against a behavioural model on every cycle, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_HEAD   = 2'd2,
    REG_TAIL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int ST_PEND_BIT  = 0;
  localparam int ST_OVF_BIT   = 1;
endpackage

// File: rtl/evlog_ptr.sv
module evlog_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             full
);
  logic [PTR_W-1:0] tail_q;
  logic [PTR_W-1:0] tail_nx;

  always_comb begin
    tail_nx = tail_q + 1'b1;
    full    = (tail_nx == head);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (adv) begin
      tail_q <= tail_nx;
    end
  end

  assign tail = tail_q;
endmodule

// File: rtl/evlog_gate.sv
module evlog_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic full,
  input  logic ovf,
  input  logic arm_req,
  input  logic disarm,
  output logic evt_ready,
  output logic do_write,
  output logic set_ovf,
  output logic active
);
  logic active_q;
  logic active_d;
  logic fire;

  always_comb begin
    evt_ready = active_q | ovf;
    fire      = evt_valid & evt_ready;
    do_write  = fire & active_q & ~full;
    set_ovf   = fire & active_q & full;
    active_d  = active_q;
    if (disarm) begin
      active_d = 1'b0;
    end else if (arm_req && !ovf) begin
      active_d = 1'b1;
    end else if (set_ovf) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/evlog_regs.sv
module evlog_regs
  import evlog_pkg::*;
#(
  parameter int PTR_W = 3,
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             set_pend,
  input  logic             set_ovf,
  input  logic [PTR_W-1:0] tail,
  output logic [CSR_W-1:0] rdata,
  output logic             log_en,
  output logic             int_en,
  output logic             pend,
  output logic             ovf,
  output logic [PTR_W-1:0] head,
  output logic             arm_req,
  output logic             disarm,
  output logic             irq
);
  logic             en_q, ie_q, pend_q, ovf_q;
  logic             pend_d, ovf_d;
  logic [PTR_W-1:0] head_q;
  logic             ctrl_wr, st_wr, head_wr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[CSR_W-1:PTR_W];

  always_comb begin
    ctrl_wr = wr_en && (reg_sel_e'(addr) == REG_CTRL);
    st_wr   = wr_en && (reg_sel_e'(addr) == REG_STATUS);
    head_wr = wr_en && (reg_sel_e'(addr) == REG_HEAD);
    arm_req = ctrl_wr & wdata[CTRL_EN_BIT] & ~en_q;
    disarm  = ctrl_wr & ~wdata[CTRL_EN_BIT];
    pend_d  = (pend_q & ~(st_wr & wdata[ST_PEND_BIT])) | set_pend;
    ovf_d   = (ovf_q  & ~(st_wr & wdata[ST_OVF_BIT]))  | set_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q <= wdata[CTRL_EN_BIT];
      ie_q <= wdata[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_wr) begin
      head_q <= wdata[PTR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      REG_CTRL: begin
        rdata[CTRL_EN_BIT] = en_q;
        rdata[CTRL_IE_BIT] = ie_q;
      end
      REG_STATUS: begin
        rdata[ST_PEND_BIT] = pend_q;
        rdata[ST_OVF_BIT]  = ovf_q;
      end
      REG_HEAD: rdata[PTR_W-1:0] = head_q;
      REG_TAIL: rdata[PTR_W-1:0] = tail;
      default:  rdata = '0;
    endcase
  end

  assign log_en = en_q;
  assign int_en = ie_q;
  assign pend   = pend_q;
  assign ovf    = ovf_q;
  assign head   = head_q;
  assign irq    = ie_q & (pend_q | ovf_q);
endmodule

// File: rtl/evlog_ring.sv
module evlog_ring #(
  parameter int DEPTH = 8,
  parameter int REC_W = 32,
  parameter int CSR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  input  logic [REC_W-1:0]         evt_data,
  output logic                     evt_ready,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [REC_W-1:0]         mem_wdata,
  input  logic                     reg_wr_en,
  input  logic [1:0]               reg_addr,
  input  logic [CSR_W-1:0]         reg_wdata,
  output logic [CSR_W-1:0]         reg_rdata,
  output logic                     irq
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             ring_full, do_write, set_ovf;
  logic             ctl_log_en, ctl_int_en, st_pend, st_ovf;
  logic             arm_req, disarm, log_active;

  evlog_regs #(.PTR_W(PTR_W), .CSR_W(CSR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .set_pend(do_write),
    .set_ovf (set_ovf),
    .tail    (tail_ptr),
    .rdata   (reg_rdata),
    .log_en  (ctl_log_en),
    .int_en  (ctl_int_en),
    .pend    (st_pend),
    .ovf     (st_ovf),
    .head    (head_ptr),
    .arm_req (arm_req),
    .disarm  (disarm),
    .irq     (irq)
  );

  evlog_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (do_write),
    .head (head_ptr),
    .tail (tail_ptr),
    .full (ring_full)
  );

  evlog_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_valid(evt_valid),
    .full     (ring_full),
    .ovf      (st_ovf),
    .arm_req  (arm_req),
    .disarm   (disarm),
    .evt_ready(evt_ready),
    .do_write (do_write),
    .set_ovf  (set_ovf),
    .active   (log_active)
  );

  assign mem_we    = do_write;
  assign mem_addr  = tail_ptr;
  assign mem_wdata = evt_data;
endmodule

// File: rtl/evlog_ring_chk.sv
module evlog_ring_chk #(
  parameter int DEPTH = 8,
  parameter int CSR_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     evt_ready,
  input logic                     mem_we,
  input logic                     irq,
  input logic                     reg_wr_en,
  input logic [1:0]               reg_addr,
  input logic [CSR_W-1:0]         reg_wdata,
  input logic                     ovf,
  input logic                     pend,
  input logic                     int_en,
  input logic                     log_en,
  input logic                     active,
  input logic [$clog2(DEPTH)-1:0] head,
  input logic [$clog2(DEPTH)-1:0] tail
);
  localparam int PTR_W = $clog2(DEPTH);
  logic [PTR_W-1:0] tail_nx;
  assign tail_nx = tail + 1'b1;

  // R4
  no_write_in_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !ovf);
  // R4
  ready_in_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> evt_ready);
  // R3
  spare_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (tail_nx != head));
  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (tail == $past(tail_nx)));
  // R2
  pend_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> pend);
  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(reg_wr_en && reg_addr == 2'd1 && reg_wdata[1]));
  // R7
  irq_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && int_en) |-> irq);
  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(reg_wr_en && reg_addr == 2'd0 && reg_wdata[0] && !log_en && !ovf));
  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd0 && !reg_wdata[0]) |=> !mem_we);
endmodule

bind evlog_ring evlog_ring_chk #(.DEPTH(DEPTH), .CSR_W(CSR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_ready(evt_ready),
  .mem_we   (mem_we),
  .irq      (irq),
  .reg_wr_en(reg_wr_en),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .ovf      (st_ovf),
  .pend     (st_pend),
  .int_en   (ctl_int_en),
  .log_en   (ctl_log_en),
  .active   (log_active),
  .head     (head_ptr),
  .tail     (tail_ptr)
);

// File: tb/evlog_ring_bench.sv
`timescale 1ns/1ps
module evlog_ring_bench;
  localparam int DEPTH = 8;
  localparam int REC_W = 32;
  localparam int CSR_W = 32;

  logic             clk;
  logic             rst_n;
  logic             evt_valid;
  logic [REC_W-1:0] evt_data;
  logic             evt_ready;
  logic             mem_we;
  logic [2:0]       mem_addr;
  logic [REC_W-1:0] mem_wdata;
  logic             reg_wr_en;
  logic [1:0]       reg_addr;
  logic [CSR_W-1:0] reg_wdata;
  logic [CSR_W-1:0] reg_rdata;
  logic             irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_head, m_tail, m_act, m_ovf, m_pend, m_en, m_ie;

  evlog_ring #(.DEPTH(DEPTH), .REC_W(REC_W), .CSR_W(CSR_W)) u_evlog_ring (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
    .evt_ready(evt_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_full();
    return ((m_tail + 1) % DEPTH) == m_head;
  endfunction

  function automatic int m_rd(input int a);
    case (a)
      0: return m_en | (m_ie << 1);
      1: return m_pend | (m_ovf << 1);
      2: return m_head;
      default: return m_tail;
    endcase
  endfunction

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_head = 0; m_tail = 0; m_act = 0; m_ovf = 0;
      m_pend = 0; m_en = 0; m_ie = 0;
    end else begin
      int rdy, fire, full, wr, ov, a, d;
      rdy  = m_act | m_ovf;
      fire = evt_valid && rdy;
      full = m_full();
      wr   = fire && m_act && !full;
      ov   = fire && m_act && full;
      a    = reg_addr;
      d    = reg_wdata;
      if (reg_wr_en && a == 1) begin
        if (d & 1) m_pend = 0;
        if (d & 2) m_ovf  = 0;
      end
      if (reg_wr_en && a == 0) begin
        if ((d & 1) == 0) m_act = 0;
        else if (m_en == 0 && m_ovf == 0 && !(reg_wr_en && a == 1 && 1'b0)) m_act = 1;
      end
      if (wr) begin
        m_tail = (m_tail + 1) % DEPTH;
        m_pend = 1;
      end
      if (ov) begin
        m_ovf = 1;
        m_act = 0;
      end
      if (reg_wr_en && a == 0) begin
        m_en = d & 1;
        m_ie = (d >> 1) & 1;
      end
      if (reg_wr_en && a == 2) m_head = d % DEPTH;
    end
  end

  // Compare all outputs with the model in the middle of the low phase.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int exp_we;
      exp_we = evt_valid && m_act && !m_full();
      check("R2 mem_we", mem_we, exp_we);
      if (exp_we) begin
        check("R2 mem_addr", mem_addr, m_tail);
        check("R2 mem_wdata", mem_wdata, evt_data);
      end
      check("R8 evt_ready", evt_ready, m_act | m_ovf);
      check("R7 irq", irq, m_ie & (m_pend | m_ovf));
      check("R10 reg_rdata", reg_rdata, m_rd(reg_addr));
    end
  end

  task automatic idle();
    @(negedge clk);
    evt_valid = 0; reg_wr_en = 0;
  endtask

  task automatic push(input int data);
    @(negedge clk);
    evt_valid = 1; evt_data = data; reg_wr_en = 0;
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk);
    evt_valid = 0; reg_wr_en = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic push_wreg(input int data, input int a, input int d);
    @(negedge clk);
    evt_valid = 1; evt_data = data;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic expect_reg(input int a, input int exp, input string tag);
    @(negedge clk);
    evt_valid = 0; reg_wr_en = 0; reg_addr = a;
    #3;
    check(tag, reg_rdata, exp);
  endtask

  task automatic expect_ready(input int exp, input string tag);
    @(negedge clk);
    evt_valid = 0; reg_wr_en = 0;
    #3;
    check(tag, evt_ready, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    rst_n = 0; evt_valid = 0; evt_data = '0;
    reg_wr_en = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset values
    expect_reg(0, 0, "R1 ctrl");
    expect_reg(1, 0, "R1 status");
    expect_reg(2, 0, "R1 head");
    expect_reg(3, 0, "R1 tail");
    expect_ready(0, "R1 evt_ready");
    check("R1 irq", irq, 0);

    // R2 fill the ring to DEPTH-1 entries
    wreg(0, 3);
    for (int i = 0; i < DEPTH - 1; i++) push(100 + i);
    expect_reg(3, 7, "R2 tail after fill");
    expect_reg(1, 1, "R2 pending set");

    // R3 one more record overflows
    push(200);
    expect_reg(1, 3, "R3 overflow set");
    expect_reg(3, 7, "R3 tail unchanged");

    // R4 drops continue after head frees space
    wreg(2, 4);
    push(300); push(301);
    expect_reg(3, 7, "R4 no write while overflow");
    expect_ready(1, "R4 ready high in overflow");

    // R6 re-arm while overflow still set has no effect
    wreg(0, 2); wreg(0, 3);
    push(302);
    expect_reg(3, 7, "R6 rearm blocked by overflow");
    wreg(1, 2);
    expect_reg(1, 1, "R5 overflow cleared");
    expect_ready(0, "R6 inactive after clear");
    wreg(0, 3);
    expect_ready(0, "R6 one while one no restart");
    wreg(0, 2); wreg(0, 3);
    expect_ready(1, "R6 zero then one restarts");
    push(400);
    expect_reg(3, 0, "R2 tail wraps");

    // R5 write-one-to-clear behaviour
    wreg(1, 0);
    expect_reg(1, 1, "R5 write zero keeps");
    wreg(1, 1);
    expect_reg(1, 0, "R5 write one clears");
    push_wreg(401, 1, 1);
    expect_reg(1, 1, "R5 set beats clear");

    // R7 interrupt enable gating
    wreg(0, 1);
    idle();
    #3 check("R7 irq masked", irq, 0);
    wreg(0, 3);
    idle();
    #3 check("R7 irq pending", irq, 1);

    // R8 disable stops writes, keeps pointers
    push_wreg(402, 0, 2);
    push(403);
    #3 check("R8 no write when disabled", mem_we, 0);
    check("R8 ready low when disabled", evt_ready, 0);
    expect_reg(3, 2, "R8 tail kept");
    expect_reg(2, 4, "R8 head kept");

    // R9 tail read-only, head write changes full decision
    wreg(3, 5);
    expect_reg(3, 2, "R9 tail write ignored");
    wreg(2, 3);
    expect_reg(2, 3, "R9 head loaded");
    wreg(0, 3);
    push(500);
    expect_reg(1, 3, "R9 full with new head");
    expect_reg(3, 2, "R3 dropped record");
    wreg(1, 1);
    expect_reg(1, 2, "R7 overflow only");
    #1 check("R7 irq on overflow", irq, 1);
    wreg(0, 1);
    idle();
    #3 check("R7 irq masked overflow", irq, 0);

    idle(); idle();
    finish_run();
  end
endmodule